// File: doc/BRIEF.md
# Dual-Buffer Transmit Register Interface

This block is the transmit half of a small memory-mapped Ethernet MAC. A 32-bit slave port exposes an 8 KiB window with two packet buffers. Each buffer has a length register, a global-interrupt-enable register and a control register. Software fills a buffer with frame bytes and writes the frame length. It then writes the control register. Depending on the command bits, the block either streams the buffered bytes out on a byte-wide valid/ready/last interface or copies the first six buffer bytes into the station address register.

A single engine serves both buffers, so commands never overlap. A command given to an idle buffer while the other buffer is still being served waits its turn. When an operation finishes, the block can raise a one-cycle interrupt pulse. The pulse depends on an enable bit in that buffer's control register and on a global enable bit that only buffer 0's register set carries.

Top module: `ethtx_dualbuf`

## Requirements
- R1: After reset the length, global-enable and control registers of both buffers read zero, `station_mac` is zero, and `tx_valid` and `irq` are low.
- R2: Buffer 0 words sit at byte offsets 0x000 to 0x7E0 and buffer 1 words at 0x800 to 0xFE0; address bit 11 picks the buffer; each word reads back as written; byte k of a buffer is lane k mod 4 (bits 8*(k mod 4)+7 down to 8*(k mod 4)) of word k/4.
- R3: The length register (offset 0x7F4, +0x800 for buffer 1) and the global-enable register (0x7F8, +0x800) read back the full written word. The control register (0x7FC, +0x800) keeps every written bit, except that bit 1 (P) is stored as 0 when bit 0 (S) is written 0; such a write starts nothing.
- R4: Offsets 0x7E4 to 0x7F0 of either half, and every offset at or above 0x1000, read as zero, and writes to them change nothing.
- R5: Every read request gets `rsp_valid` in the next cycle. An access whose `req_strb` is not 4'hF is rejected: a write has no effect and a read returns zero.
- R6: Writing control with S=1, P=0 sends that buffer's bytes 0 to length-1 in order on `tx_data`. `tx_last` is high only with the final byte, and data is held while `tx_ready` is low.
- R7: A length above 2020 bytes (0x7E4) sends exactly 2020 bytes. A length of zero sends no byte but still completes the operation.
- R8: Writing control with S=1, P=1 sends nothing and loads `station_mac` with buffer bytes 0 to 5, byte 0 in bits 47:40.
- R9: S and P read back as written (1) while the operation is pending or running, and both read 0 once it completes; other control bits stay unchanged.
- R10: A control write to a buffer whose S bit reads 1 is ignored entirely.
- R11: A completed operation gives a one-cycle `irq` pulse exactly when bit 3 of that buffer's control register and bit 31 of buffer 0's global-enable register are set; buffer 1's global-enable register has no effect.
- R12: A command accepted by one buffer while the other is being served runs after it, and the two byte streams do not interleave.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address within the 8 KiB window |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte enables; only 4'hF is accepted |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | `tx_data` holds a byte |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| station_mac | output | 48 | Station address, first byte in bits 47:40 |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
A wrong byte-lane select or an off-by-one in the byte counter shows up in the captured stream on the first frame. The symptoms are a wrong data byte, `tx_last` on the wrong byte, or a wrong byte count. The bench compares every byte against an arithmetic pattern over a sweep of lengths and back-pressure patterns. Stuck or stale command bits show up within a few polling reads as S never clearing, as a second operation that nobody asked for, or as an extra or missing `irq` pulse. A full sweep of the three enable bits checks the interrupt gating on both buffers.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;

    // Word index inside one 2 KiB half of the window
    localparam int unsigned HALF_WORD_W = 9;
    localparam logic [HALF_WORD_W-1:0] WI_LEN  = 9'd509;
    localparam logic [HALF_WORD_W-1:0] WI_GIE  = 9'd510;
    localparam logic [HALF_WORD_W-1:0] WI_CTRL = 9'd511;

    // Control and enable bit positions
    localparam int unsigned BIT_SEND = 0;
    localparam int unsigned BIT_PROG = 1;
    localparam int unsigned BIT_IEN  = 3;
    localparam int unsigned BIT_GLOB = 31;

    typedef enum logic [2:0] {
        K_NONE,
        K_BUFW,
        K_LEN,
        K_GIE,
        K_CTRL
    } kind_e;

    typedef struct packed {
        kind_e                  kind;
        logic                   sel;
        logic [HALF_WORD_W-1:0] word;
    } dec_t;

    typedef enum logic [2:0] {
        E_IDLE,
        E_SEND,
        E_LDLO,
        E_LDHI,
        E_DONE
    } eng_e;

    // Decode a word address (byte address bits 12:2)
    function automatic dec_t win_decode(input logic [10:0] wa, input int unsigned words);
        dec_t d;
        d.sel  = wa[9];
        d.word = wa[8:0];
        if (wa[10]) begin
            d.kind = K_NONE;
        end else if (wa[8:0] == WI_LEN) begin
            d.kind = K_LEN;
        end else if (wa[8:0] == WI_GIE) begin
            d.kind = K_GIE;
        end else if (wa[8:0] == WI_CTRL) begin
            d.kind = K_CTRL;
        end else if (32'(wa[8:0]) < words) begin
            d.kind = K_BUFW;
        end else begin
            d.kind = K_NONE;
        end
        return d;
    endfunction

    // Control word as stored: P dropped unless S is written
    function automatic logic [31:0] ctrl_store(input logic [31:0] w);
        logic [31:0] r;
        r = w;
        if (!w[BIT_SEND]) r[BIT_PROG] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ethtx_bufram.sv
module ethtx_bufram #(
    parameter int unsigned WORDS = 505,
    parameter int unsigned AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic          rd_en,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata,
    input  logic [AW-1:0] eaddr,
    output logic [31:0]   edata
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rdata <= mem[raddr];
    end

    assign edata = mem[eaddr];
endmodule

// File: rtl/ethtx_regs.sv
module ethtx_regs import ethtx_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  kind_e            wr_kind,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    input  kind_e            rd_kind,
    input  logic             rd_sel,
    output logic [31:0]      rd_val,
    output logic [1:0][31:0] len_q,
    output logic [1:0]       cmd_s,
    output logic [1:0]       cmd_p,
    input  logic             eng_done,
    input  logic             eng_buf,
    input  logic             mac_we,
    input  logic [47:0]      mac_val,
    output logic [47:0]      station_mac,
    output logic             irq,
    output logic             gie_on
);
    logic [1:0][31:0] gie_q;
    logic [1:0][31:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q       <= '0;
            gie_q       <= '0;
            ctrl_q      <= '0;
            station_mac <= '0;
            irq         <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_kind)
                    K_LEN: len_q[wr_sel] <= wr_data;
                    K_GIE: gie_q[wr_sel] <= wr_data;
                    K_CTRL: begin
                        if (!ctrl_q[wr_sel][BIT_SEND]) ctrl_q[wr_sel] <= ctrl_store(wr_data);
                    end
                    default: ;
                endcase
            end
            if (eng_done) begin
                ctrl_q[eng_buf][BIT_SEND] <= 1'b0;
                ctrl_q[eng_buf][BIT_PROG] <= 1'b0;
            end
            if (mac_we) station_mac <= mac_val;
            irq <= eng_done && ctrl_q[eng_buf][BIT_IEN] && gie_q[0][BIT_GLOB];
        end
    end

    always_comb begin
        case (rd_kind)
            K_LEN:   rd_val = len_q[rd_sel];
            K_GIE:   rd_val = gie_q[rd_sel];
            K_CTRL:  rd_val = ctrl_q[rd_sel];
            default: rd_val = '0;
        endcase
    end

    for (genvar b = 0; b < 2; b++) begin : g_cmd
        assign cmd_s[b] = ctrl_q[b][BIT_SEND];
        assign cmd_p[b] = ctrl_q[b][BIT_PROG];
    end

    assign gie_on = gie_q[0][BIT_GLOB];
endmodule

// File: rtl/ethtx_engine.sv
module ethtx_engine import ethtx_pkg::*; #(
    parameter int unsigned BUF_BYTES = 2020,
    parameter int unsigned WORD_AW   = 9,
    parameter int unsigned CNT_W     = WORD_AW + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cmd_s,
    input  logic [1:0]         cmd_p,
    input  logic [1:0][31:0]   len_q,
    output logic [WORD_AW-1:0] rd_addr,
    input  logic [1:0][31:0]   rd_word,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               tx_last,
    output logic               done,
    output logic               done_buf,
    output logic               mac_we,
    output logic [47:0]        mac_val
);
    eng_e             st;
    logic             cur;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tot;
    logic [31:0]      lo_q;
    logic             pick;
    logic [CNT_W-1:0] pick_len;
    logic [31:0]      word;

    assign pick     = cmd_s[0] ? 1'b0 : 1'b1;
    assign pick_len = (len_q[pick] > 32'(BUF_BYTES)) ? CNT_W'(BUF_BYTES)
                                                     : len_q[pick][CNT_W-1:0];
    assign word     = rd_word[cur];

    always_comb begin
        case (st)
            E_LDLO:  rd_addr = '0;
            E_LDHI:  rd_addr = WORD_AW'(1);
            default: rd_addr = cnt[CNT_W-1:2];
        endcase
    end

    assign tx_valid = (st == E_SEND);
    assign tx_data  = word[8*cnt[1:0] +: 8];
    assign tx_last  = tx_valid && (cnt == tot - CNT_W'(1));
    assign done     = (st == E_DONE);
    assign done_buf = cur;
    assign mac_we   = (st == E_LDHI);
    assign mac_val  = {lo_q[7:0], lo_q[15:8], lo_q[23:16], lo_q[31:24],
                       word[7:0], word[15:8]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= E_IDLE;
            cur  <= 1'b0;
            cnt  <= '0;
            tot  <= '0;
            lo_q <= '0;
        end else begin
            case (st)
                E_IDLE: begin
                    if (|cmd_s) begin
                        cur <= pick;
                        cnt <= '0;
                        tot <= pick_len;
                        if (cmd_p[pick])         st <= E_LDLO;
                        else if (pick_len == '0) st <= E_DONE;
                        else                     st <= E_SEND;
                    end
                end
                E_SEND: begin
                    if (tx_ready) begin
                        if (tx_last) st <= E_DONE;
                        else         cnt <= cnt + CNT_W'(1);
                    end
                end
                E_LDLO: begin
                    lo_q <= word;
                    st   <= E_LDHI;
                end
                E_LDHI:  st <= E_DONE;
                default: st <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ethtx_dualbuf.sv
module ethtx_dualbuf import ethtx_pkg::*; #(
    parameter int unsigned BUF_BYTES = 2020
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [12:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  req_strb,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        tx_last,
    output logic [47:0] station_mac,
    output logic        irq
);
    localparam int unsigned BUF_WORDS = (BUF_BYTES + 3) / 4;
    localparam int unsigned WORD_AW   = $clog2(BUF_WORDS);
    localparam int unsigned CNT_W     = WORD_AW + 2;

    dec_t             dec;
    logic             acc_ok;
    logic             rd_req;
    logic [1:0][31:0] bus_word;
    logic [1:0][31:0] eng_word;
    logic [WORD_AW-1:0] eng_addr;
    logic [31:0]      reg_val;
    logic [31:0]      reg_rd_q;
    kind_e            rd_kind_q;
    logic             rd_sel_q;
    logic [1:0][31:0] len_q;
    logic [1:0]       cmd_s;
    logic [1:0]       cmd_p;
    logic             eng_done;
    logic             eng_buf;
    logic             mac_we;
    logic [47:0]      mac_val;
    logic             gie_on;

    assign dec    = win_decode(req_addr[12:2], BUF_WORDS);
    assign acc_ok = req_valid && (req_strb == 4'hF);
    assign rd_req = acc_ok && !req_write;

    for (genvar b = 0; b < 2; b++) begin : g_buf
        ethtx_bufram #(.WORDS(BUF_WORDS), .AW(WORD_AW)) u_ram (
            .clk   (clk),
            .we    (acc_ok && req_write && dec.kind == K_BUFW && dec.sel == 1'(b)),
            .waddr (dec.word[WORD_AW-1:0]),
            .wdata (req_wdata),
            .rd_en (rd_req && dec.kind == K_BUFW && dec.sel == 1'(b)),
            .raddr (dec.word[WORD_AW-1:0]),
            .rdata (bus_word[b]),
            .eaddr (eng_addr),
            .edata (eng_word[b])
        );
    end

    ethtx_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (acc_ok && req_write),
        .wr_kind     (dec.kind),
        .wr_sel      (dec.sel),
        .wr_data     (req_wdata),
        .rd_kind     (dec.kind),
        .rd_sel      (dec.sel),
        .rd_val      (reg_val),
        .len_q       (len_q),
        .cmd_s       (cmd_s),
        .cmd_p       (cmd_p),
        .eng_done    (eng_done),
        .eng_buf     (eng_buf),
        .mac_we      (mac_we),
        .mac_val     (mac_val),
        .station_mac (station_mac),
        .irq         (irq),
        .gie_on      (gie_on)
    );

    ethtx_engine #(.BUF_BYTES(BUF_BYTES), .WORD_AW(WORD_AW), .CNT_W(CNT_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .cmd_s    (cmd_s),
        .cmd_p    (cmd_p),
        .len_q    (len_q),
        .rd_addr  (eng_addr),
        .rd_word  (eng_word),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_last  (tx_last),
        .done     (eng_done),
        .done_buf (eng_buf),
        .mac_we   (mac_we),
        .mac_val  (mac_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rd_kind_q <= K_NONE;
            rd_sel_q  <= 1'b0;
            reg_rd_q  <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rd_kind_q <= rd_req ? dec.kind : K_NONE;
            rd_sel_q  <= dec.sel;
            reg_rd_q  <= rd_req ? reg_val : '0;
        end
    end

    assign rsp_rdata = (rd_kind_q == K_BUFW) ? bus_word[rd_sel_q] : reg_rd_q;
endmodule

// File: rtl/ethtx_checker.sv
module ethtx_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_write,
    input logic       rsp_valid,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_last,
    input logic       irq,
    input logic       gie_on
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!tx_valid && !irq));

    assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_stray_rsp_R5: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_last_valid_R6: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    assert_irq_single_R11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(gie_on));
endmodule

bind ethtx_dualbuf ethtx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_last   (tx_last),
    .irq       (irq),
    .gie_on    (gie_on)
);

// File: tb/sim_ethtx_dualbuf.sv
`timescale 1ns/1ps
module sim_ethtx_dualbuf;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_strb = 4'hF;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic        tx_last;
    logic [47:0] station_mac;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int rdy_mode = 0;
    int rcyc = 0;
    logic [7:0] cap [0:4095];
    int cap_n = 0;
    int last_at = -1;
    int n_last = 0;
    int irq_n = 0;

    always #4 clk = ~clk;

    ethtx_dualbuf u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
        .station_mac(station_mac), .irq(irq)
    );

    always @(posedge clk) begin
        rcyc <= rcyc + 1;
        case (rdy_mode)
            0:       tx_ready <= 1'b1;
            1:       tx_ready <= rcyc[0];
            2:       tx_ready <= (rcyc % 3 == 0);
            default: tx_ready <= 1'b0;
        endcase
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_valid && tx_ready && cap_n < 4096) begin
                cap[cap_n] = tx_data;
                if (tx_last) begin
                    last_at = cap_n;
                    n_last  = n_last + 1;
                end
                cap_n = cap_n + 1;
            end
            if (irq) irq_n = irq_n + 1;
        end
    end

    function automatic logic [7:0] bv(input int b, input int k);
        return 8'((k * 7 + b * 64 + 3) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [12:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_strb = s;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_strb = 4'hF;
    endtask

    task automatic bus_rd(input logic [12:0] a, input logic [3:0] s, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_strb = s;
        @(negedge clk);
        req_valid = 1'b0; req_strb = 4'hF;
        d = rsp_rdata;
        if (!rsp_valid) check(1'b0, "R5", "rsp_valid", 0, 1);
    endtask

    task automatic fill(input int b, input int words);
        for (int k = 0; k < words; k++)
            bus_wr(13'(b * 2048 + 4 * k),
                   {bv(b, 4*k+3), bv(b, 4*k+2), bv(b, 4*k+1), bv(b, 4*k)}, 4'hF);
    endtask

    task automatic wait_idle(input int b, input string req);
        logic [31:0] d;
        int polls = 0;
        d = 32'h1;
        while (d[0] && polls < 6000) begin
            bus_rd(13'(b * 2048 + 12'h7FC), 4'hF, d);
            polls++;
        end
        if (d[0]) check(1'b0, req, "completion timeout", polls, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_cap();
        cap_n = 0; last_at = -1; n_last = 0;
    endtask

    initial begin
        #(8 * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [47:0] mac_keep;
        int irq0;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_rd(13'h7F4, 4'hF, d); check(d == 0, "R1", "len0", d, 0);
        bus_rd(13'h7F8, 4'hF, d); check(d == 0, "R1", "gie0", d, 0);
        bus_rd(13'h7FC, 4'hF, d); check(d == 0, "R1", "ctrl0", d, 0);
        bus_rd(13'hFFC, 4'hF, d); check(d == 0, "R1", "ctrl1", d, 0);
        check(station_mac == 0, "R1", "mac", station_mac, 0);
        check(!tx_valid && irq_n == 0, "R1", "tx_valid/irq", {tx_valid, 31'(irq_n)}, 0);

        // R3: register readback and control storage
        bus_wr(13'h7F4, 32'h12345678, 4'hF);
        bus_rd(13'h7F4, 4'hF, d); check(d == 32'h12345678, "R3", "len0", d, 32'h12345678);
        bus_wr(13'hFF8, 32'hDEAD0001, 4'hF);
        bus_rd(13'hFF8, 4'hF, d); check(d == 32'hDEAD0001, "R3", "gie1", d, 32'hDEAD0001);
        bus_wr(13'h7FC, 32'h000000F6, 4'hF);
        bus_rd(13'h7FC, 4'hF, d); check(d == 32'h000000F4, "R3", "ctrl0 P dropped", d, 32'hF4);
        repeat (4) @(negedge clk);
        check(cap_n == 0 && irq_n == 0, "R3", "no op started", cap_n, 0);
        bus_wr(13'h7FC, 32'h0, 4'hF);
        bus_wr(13'hFF8, 32'h0, 4'hF);

        // R2: buffer word readback, both halves
        bus_wr(13'h000, 32'hA0A1A2A3, 4'hF);
        bus_wr(13'h7E0, 32'hB0B1B2B3, 4'hF);
        bus_wr(13'h800, 32'hC0C1C2C3, 4'hF);
        bus_wr(13'hFE0, 32'hD0D1D2D3, 4'hF);
        bus_rd(13'h000, 4'hF, d); check(d == 32'hA0A1A2A3, "R2", "buf0 w0", d, 32'hA0A1A2A3);
        bus_rd(13'h7E0, 4'hF, d); check(d == 32'hB0B1B2B3, "R2", "buf0 w504", d, 32'hB0B1B2B3);
        bus_rd(13'h800, 4'hF, d); check(d == 32'hC0C1C2C3, "R2", "buf1 w0", d, 32'hC0C1C2C3);
        bus_rd(13'hFE0, 4'hF, d); check(d == 32'hD0D1D2D3, "R2", "buf1 w504", d, 32'hD0D1D2D3);

        // R4: reserved and unmapped offsets
        bus_wr(13'h7E8, 32'h55555555, 4'hF);
        bus_rd(13'h7E8, 4'hF, d); check(d == 0, "R4", "0x7E8", d, 0);
        bus_rd(13'hFF0, 4'hF, d); check(d == 0, "R4", "0xFF0", d, 0);
        bus_wr(13'h1000, 32'h66666666, 4'hF);
        bus_rd(13'h1000, 4'hF, d); check(d == 0, "R4", "0x1000", d, 0);
        bus_rd(13'h000, 4'hF, d); check(d == 32'hA0A1A2A3, "R4", "no alias", d, 32'hA0A1A2A3);
        bus_rd(13'h1FFC, 4'hF, d); check(d == 0, "R4", "0x1FFC", d, 0);

        // R5: partial accesses rejected
        bus_wr(13'h000, 32'h99999999, 4'h3);
        bus_rd(13'h000, 4'hF, d); check(d == 32'hA0A1A2A3, "R5", "partial write", d, 32'hA0A1A2A3);
        bus_rd(13'h7F4, 4'h1, d); check(d == 0, "R5", "partial read", d, 0);

        // R6, R11: send sweep over lengths, buffers and back-pressure
        bus_wr(13'h7F8, 32'h80000000, 4'hF);
        for (int b = 0; b < 2; b++) begin
            fill(b, 4);
            for (int len = 1; len <= 9; len++) begin
                rdy_mode = len % 3;
                clear_cap();
                irq0 = irq_n;
                bus_wr(13'(b * 2048 + 12'h7F4), 32'(len), 4'hF);
                bus_wr(13'(b * 2048 + 12'h7FC), 32'h9, 4'hF);
                wait_idle(b, "R6");
                check(cap_n == len, "R6", "byte count", cap_n, len);
                bad = 0;
                for (int k = 0; k < len; k++) if (cap[k] != bv(b, k)) bad++;
                check(bad == 0, "R6", "byte order", bad, 0);
                check(n_last == 1 && last_at == len - 1, "R6", "last position", last_at, len - 1);
                check(irq_n - irq0 == 1, "R11", "send irq", irq_n - irq0, 1);
            end
        end
        rdy_mode = 0;

        // R7: zero length and clamp
        clear_cap();
        irq0 = irq_n;
        bus_wr(13'h7F4, 32'h0, 4'hF);
        bus_wr(13'h7FC, 32'h9, 4'hF);
        wait_idle(0, "R7");
        check(cap_n == 0, "R7", "zero length bytes", cap_n, 0);
        check(irq_n - irq0 == 1, "R7", "zero length completes", irq_n - irq0, 1);
        fill(1, 505);
        clear_cap();
        bus_wr(13'hFF4, 32'h0000FFFF, 4'hF);
        bus_wr(13'hFFC, 32'h1, 4'hF);
        wait_idle(1, "R7");
        check(cap_n == 2020, "R7", "clamped count", cap_n, 2020);
        bad = 0;
        for (int k = 0; k < 2020; k++) if (cap[k] != bv(1, k)) bad++;
        check(bad == 0, "R7", "clamped data", bad, 0);
        check(last_at == 2019, "R7", "clamped last", last_at, 2019);

        // R8: station address load
        clear_cap();
        irq0 = irq_n;
        bus_wr(13'h000, 32'h44332211, 4'hF);
        bus_wr(13'h004, 32'h00006655, 4'hF);
        bus_wr(13'h7FC, 32'h3, 4'hF);
        wait_idle(0, "R8");
        check(station_mac == 48'h112233445566, "R8", "mac buf0", station_mac, 48'h112233445566);
        check(cap_n == 0, "R8", "no stream", cap_n, 0);
        check(irq_n == irq0, "R11", "ien clear no irq", irq_n - irq0, 0);
        bus_wr(13'hFFC, 32'h3, 4'hF);
        wait_idle(1, "R8");
        check(station_mac == {bv(1,0), bv(1,1), bv(1,2), bv(1,3), bv(1,4), bv(1,5)},
              "R8", "mac buf1", station_mac,
              {bv(1,0), bv(1,1), bv(1,2), bv(1,3), bv(1,4), bv(1,5)});

        // R11: gating sweep
        for (int b = 0; b < 2; b++)
            for (int m = 0; m < 8; m++) begin
                bus_wr(13'h7F8, {m[1], 31'h0}, 4'hF);
                bus_wr(13'hFF8, {m[2], 31'h0}, 4'hF);
                irq0 = irq_n;
                bus_wr(13'(b * 2048 + 12'h7FC), {28'h0, m[0], 3'b011}, 4'hF);
                wait_idle(b, "R11");
                check(irq_n - irq0 == int'(m[0] && m[1]), "R11", "gating",
                      irq_n - irq0, 64'(m[0] && m[1]));
            end
        bus_wr(13'h7F8, 32'h80000000, 4'hF);

        // R9, R10: busy readback and ignored command
        fill(0, 2);
        rdy_mode = 3;
        repeat (2) @(negedge clk);
        clear_cap();
        mac_keep = station_mac;
        bus_wr(13'h7F4, 32'h4, 4'hF);
        bus_wr(13'h7FC, 32'h9, 4'hF);
        bus_rd(13'h7FC, 4'hF, d); check(d == 32'h9, "R9", "busy S", d, 32'h9);
        bus_wr(13'h7FC, 32'hB, 4'hF);
        bus_rd(13'h7FC, 4'hF, d); check(d == 32'h9, "R10", "busy write", d, 32'h9);
        rdy_mode = 0;
        wait_idle(0, "R9");
        check(cap_n == 4, "R10", "bytes", cap_n, 4);
        check(station_mac == mac_keep, "R10", "mac kept", station_mac, mac_keep);
        bus_rd(13'h7FC, 4'hF, d); check(d == 32'h8, "R9", "cleared", d, 32'h8);

        // R12: second buffer queued behind first
        fill(1, 1);
        rdy_mode = 3;
        repeat (2) @(negedge clk);
        clear_cap();
        bus_wr(13'h7F4, 32'h3, 4'hF);
        bus_wr(13'h7FC, 32'h1, 4'hF);
        bus_wr(13'hFF4, 32'h2, 4'hF);
        bus_wr(13'hFFC, 32'h1, 4'hF);
        bus_rd(13'hFFC, 4'hF, d); check(d == 32'h1, "R12", "queued S", d, 1);
        rdy_mode = 1;
        wait_idle(0, "R12");
        wait_idle(1, "R12");
        check(cap_n == 5 && n_last == 2, "R12", "total bytes", cap_n, 5);
        bad = 0;
        for (int k = 0; k < 3; k++) if (cap[k] != bv(0, k)) bad++;
        for (int k = 0; k < 2; k++) if (cap[3 + k] != bv(1, k)) bad++;
        check(bad == 0, "R12", "stream order", bad, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule